// File: doc/BRIEF.md
# Board Control and Status Register Block

This block is a small memory-mapped peripheral on a plain 32-bit register bus. A host processor reads a fixed build identifier and the processor clock rate from it, drives a bank of board LEDs through a read/write register, and reads the state of a bank of DIP switches. The block also accepts a guarded board-reset command: writing one particular key value to the reset register raises a single-cycle request toward the system reset controller. Any other value written there is discarded.

The block answers to a 64 KiB window. Only the low 16 address bits reach it, and address bits 1:0 are not decoded. The switch inputs come from the board asynchronously, so they pass through a two-flop synchroniser before the read path uses them. Read data is registered and appears one cycle after the read enable.

Top module: `board_ctrl_regs`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, led_o is zero, rd_data_o is zero and board_rst_req_o is low.
- R2: A read of word offset 0x0 returns the build identifier 0x09272011, and writes there change nothing.
- R3: A read of offset 0x4 returns the clock frequency parameter CLK_HZ (default 10,000,000 = 0x00989680), and writes there change nothing.
- R4: A write to offset 0x8 replaces the whole LED register with wr_data_i[N_LED-1:0]. led_o shows the new value after the write edge. A read of 0x8 returns it zero-extended to 32 bits.
- R5: A read of offset 0xC returns sw_i, zero-extended, as sampled through two flops. A switch change shows in a read issued two or more edges later. Writes to 0xC change neither the LEDs nor the switch value read back.
- R6: A write of exactly 0x0000DEAD to offset 0x10 raises board_rst_req_o for exactly one cycle, starting at the clock edge that takes the write.
- R7: A write of any other value to offset 0x10 leaves board_rst_req_o low and the LED register unchanged. A read of 0x10 returns zero.
- R8: Reads from any offset in the window other than 0x0, 0x4, 0x8 and 0xC return zero. Writes to them change nothing. Examples are 0x14 and 0xFFFC.
- R9: rd_data_o holds the addressed value in the cycle after a cycle with rd_en_i high, and is zero after a cycle with rd_en_i low.
- R10: Address bits 1:0 are ignored. For example, a read of offset 0x9 returns the LED register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Byte offset within the window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| sw_i | input | N_SW | Asynchronous DIP-switch inputs |
| led_o | output | N_LED | LED register value |
| board_rst_req_o | output | 1 | One-cycle board reset request |

## Verification
The LED register is tested with alternating, all-ones and all-zero patterns. This shows whether each write replaces the whole value or merges into it, and whether any bit is stuck. The reset register gets the key value, the key with one bit flipped, the key shifted into the upper half-word, and back-to-back key writes. These separate a full 32-bit compare from a partial one and confirm that the pulse lasts one cycle. The switches are changed and then read after a delay, and writes to the identifier, frequency, switch and unmapped offsets are each followed by LED and switch readback. This shows that the decode sends each write only where it belongs.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] BUILD_ID  = 32'h0927_2011;
  localparam logic [DW-1:0] RST_KEY   = 32'h0000_DEAD;

  // word indices (byte offset >> 2)
  localparam int unsigned IDX_ID   = 0;
  localparam int unsigned IDX_FREQ = 1;
  localparam int unsigned IDX_LED  = 2;
  localparam int unsigned IDX_SW   = 3;
  localparam int unsigned IDX_RST  = 4;

  typedef enum logic [2:0] {
    SEL_ID, SEL_FREQ, SEL_LED, SEL_SW, SEL_RST, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/bctl_sync.sv
module bctl_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bctl_rst_trig.sv
module bctl_rst_trig
  import board_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [DW-1:0] data_i,
  output logic          req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= hit_i && (data_i == RST_KEY);
  end

  assign req_o = req_q;
endmodule

// File: rtl/bctl_regs.sv
module bctl_regs
  import board_ctrl_pkg::*;
#(
  parameter int unsigned   WIN_AW = 16,
  parameter int unsigned   N_LED  = 8,
  parameter int unsigned   N_SW   = 8,
  parameter logic [DW-1:0] CLK_HZ = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  input  logic [N_SW-1:0]   sw_sync_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [N_LED-1:0]  led_o,
  output logic              rst_hit_o
);
  localparam int unsigned WORD_AW = WIN_AW - 2;

  logic [WORD_AW-1:0] widx;
  reg_sel_e           sel;
  logic [N_LED-1:0]   led_q;
  logic [DW-1:0]      rd_mux, rd_q;

  assign widx = addr_i[WIN_AW-1:2];

  always_comb begin
    unique case (widx)
      WORD_AW'(IDX_ID):   sel = SEL_ID;
      WORD_AW'(IDX_FREQ): sel = SEL_FREQ;
      WORD_AW'(IDX_LED):  sel = SEL_LED;
      WORD_AW'(IDX_SW):   sel = SEL_SW;
      WORD_AW'(IDX_RST):  sel = SEL_RST;
      default:            sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_q <= '0;
    else if (wr_en_i && sel == SEL_LED) led_q <= wr_data_i[N_LED-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ID:   rd_mux = BUILD_ID;
      SEL_FREQ: rd_mux = CLK_HZ;
      SEL_LED:  rd_mux = DW'(led_q);
      SEL_SW:   rd_mux = DW'(sw_sync_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
    else              rd_q <= '0;
  end

  assign rd_data_o = rd_q;
  assign led_o     = led_q;
  assign rst_hit_o = wr_en_i && sel == SEL_RST;

  // R4: LED register follows writes to offset 0x8, holds otherwise
  assert_led_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && addr_i[WIN_AW-1:2] == WORD_AW'(IDX_LED))
      |-> led_o == $past(wr_data_i[N_LED-1:0]));
  assert_led_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && addr_i[WIN_AW-1:2] == WORD_AW'(IDX_LED)) |-> $stable(led_o));
  // R9: no read, no data
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> rd_data_o == '0);
  // R2: identifier read
  assert_id_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i[WIN_AW-1:2] == '0) |-> rd_data_o == BUILD_ID);
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int unsigned   WIN_AW = 16,
  parameter int unsigned   N_LED  = 8,
  parameter int unsigned   N_SW   = 8,
  parameter logic [DW-1:0] CLK_HZ = 32'd10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic [N_SW-1:0]   sw_i,
  output logic [N_LED-1:0]  led_o,
  output logic              board_rst_req_o
);
  logic [N_SW-1:0] sw_sync;
  logic            rst_hit;

  bctl_sync #(.W(N_SW), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(sw_i), .q_o(sw_sync)
  );

  bctl_regs #(.WIN_AW(WIN_AW), .N_LED(N_LED), .N_SW(N_SW), .CLK_HZ(CLK_HZ)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .sw_sync_i(sw_sync), .rd_data_o, .led_o, .rst_hit_o(rst_hit)
  );

  bctl_rst_trig u_trig (
    .clk_i, .rst_ni, .hit_i(rst_hit), .data_i(wr_data_i), .req_o(board_rst_req_o)
  );

  // R6/R7: request only after a key write to the reset offset, always after one
  assert_req_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_rst_req_o |-> $past(wr_en_i && addr_i[WIN_AW-1:2] == 4 && wr_data_i == RST_KEY));
  assert_req_fires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && addr_i[WIN_AW-1:2] == 4 && wr_data_i == RST_KEY) |-> board_rst_req_o);
endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  sw = '0;
  logic [7:0]  led;
  logic        req;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  board_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .sw_i(sw), .led_o(led), .board_rst_req_o(req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    d = rd_data; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    #1; chk("R1 led in reset", 32'(led), 0);
    chk("R1 req in reset", 32'(req), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 led after reset", 32'(led), 0);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 req after reset", 32'(req), 0);
  endtask

  task automatic t_ident;
    logic [31:0] d;
    wr(16'h0, 32'h1234_5678);
    rd(16'h0, d); chk("R2 build id", d, 32'h0927_2011);
    wr(16'h4, 32'h0);
    rd(16'h4, d); chk("R3 clock rate", d, 32'd10_000_000);
    @(posedge clk); #1; chk("R9 idle after read", rd_data, 0);
  endtask

  task automatic t_led;
    logic [31:0] d;
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
    foreach (pats[i]) begin
      wr(16'h8, {24'hFFFF_FF, pats[i]});
      chk("R4 led_o", 32'(led), 32'(pats[i]));
      rd(16'h8, d); chk("R4 led readback", d, 32'(pats[i]));
    end
    wr(16'h8, 32'h3C);
    rd(16'h9, d); chk("R10 low bits ignored", d, 32'h3C);
    wr(16'h0, 32'hFF); wr(16'h4, 32'hFF); wr(16'hC, 32'hFF);
    wr(16'h14, 32'hFF); wr(16'hFFFC, 32'hFF);
    chk("R8 stray writes keep led", 32'(led), 32'h3C);
  endtask

  task automatic t_sw;
    logic [31:0] d;
    @(negedge clk); sw = 8'hC3;
    repeat (2) @(posedge clk);
    rd(16'hC, d); chk("R5 switch read", d, 32'hC3);
    wr(16'hC, 32'h0);
    rd(16'hC, d); chk("R5 write to switch ignored", d, 32'hC3);
    chk("R5 write to switch keeps led", 32'(led), 32'h3C);
    @(negedge clk); sw = 8'h18;
    repeat (2) @(posedge clk);
    rd(16'hC, d); chk("R5 switch change", d, 32'h18);
  endtask

  task automatic t_rst_key;
    logic [31:0] d;
    wr(16'h10, 32'h0000_DEAD);
    chk("R6 pulse high", 32'(req), 1);
    @(posedge clk); #1; chk("R6 pulse one cycle", 32'(req), 0);
    wr(16'h10, 32'h0000_DEAC);  chk("R7 near key", 32'(req), 0);
    wr(16'h10, 32'hDEAD_0000);  chk("R7 shifted key", 32'(req), 0);
    wr(16'h10, 32'h0001_DEAD);  chk("R7 upper bit set", 32'(req), 0);
    wr(16'h14, 32'h0000_DEAD);  chk("R8 key at wrong offset", 32'(req), 0);
    chk("R7 led unchanged", 32'(led), 32'h3C);
    rd(16'h10, d); chk("R7 reset reg reads zero", d, 0);
    wr(16'h10, 32'h0000_DEAD);
    wr(16'h10, 32'h0000_DEAD);
    chk("R6 back-to-back second pulse", 32'(req), 1);
    @(posedge clk); #1; chk("R6 back-to-back ends", 32'(req), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(16'h14, d);   chk("R8 read 0x14", d, 0);
    rd(16'h100, d);  chk("R8 read 0x100", d, 0);
    rd(16'hFFFC, d); chk("R8 read 0xFFFC", d, 0);
  endtask

  initial begin
    t_reset();
    t_ident();
    t_led();
    t_sw();
    t_rst_key();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule